// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between one CPU-side request port and a word-addressed backing memory. Each 32-bit word in an alias window stands for a single bit of one byte in a target window. When the CPU master accesses an alias word, the block turns that access into a single-bit operation on the target:

- An alias read returns the addressed bit alone, zero-extended to a full word.
- An alias write reads the target word, changes that one bit and writes the word back. The read and the write form one indivisible pair.

Any access outside the alias window goes to the memory unchanged, whichever master issued it.

Both ports use a valid/ready request handshake. A request carries an address, a write enable, write data and a master tag. A response channel returns read data and an error flag. The block accepts one request at a time. It raises ready again only after the response to that request has been delivered, so nothing can come between the read and the write of an alias update.

Masters other than the CPU get no bit-band behaviour. If such a master touches the alias window, it receives an error response and nothing is sent to the memory.

Top module: `bitband_xlate`

## Requirements
- R1: A request whose address lies outside the alias window produces exactly one memory request. That memory request carries the same address, write enable, write data and master tag as the original. The memory response data is returned unchanged with the error flag clear. This holds for every master.
- R2: The alias window is [ALIAS_BASE, ALIAS_BASE + 2^SPAN_LOG2). For an address inside it:
  - the byte offset is (addr - ALIAS_BASE) >> 5 and the bit number is address bits [4:2];
  - the memory word address is TARGET_BASE + (byte offset with its two low bits cleared);
  - addresses one word below the window and exactly at its end are passed through.
- R3: A CPU alias read issues one memory read of the translated word. Its response is 32'h0000_0001 when the addressed bit is set and 32'h0000_0000 when it is clear.
- R4: A CPU alias write issues a memory read and then a memory write to the same translated word address. The written word equals the word that was read, except at the addressed bit. The response data of the alias write is zero.
- R5: For an alias write, only write-data bit 0 decides the new bit value (1 sets it, 0 clears it). All other write-data bits have no effect.
- R6: From the cycle a request is accepted until its response has been delivered, up_ready stays low, so no second request can be accepted between the read and the write of an alias update.
- R7: Target data is little-endian. Byte offset k selects bit (k mod 4)*8 + bit number within its word, so byte lane 0 is bits [7:0] and lane 3 is bits [31:24].
- R8: The CPU is the master whose tag equals CPU_ID (default 0). A request to the alias window carrying any other tag does not reach memory. It is answered with the error flag set and response data zero.
- R9: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_we and mem_wdata hold their values.
- R10: During and right after reset, up_ready is 1, mem_valid is 0 and up_rsp_valid is 0.
- R11: Every accepted request receives exactly one response, given as a one-cycle pulse of up_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | CPU-side request valid |
| up_ready | output | 1 | Request accepted on a cycle where valid and ready are both high |
| up_addr | input | AW | Request byte address |
| up_we | input | 1 | 1 for write, 0 for read |
| up_wdata | input | 32 | Write data |
| up_mid | input | IDW | Master tag of the requester |
| up_rsp_valid | output | 1 | One-cycle response pulse |
| up_rsp_data | output | 32 | Response read data |
| up_rsp_err | output | 1 | Refused alias access by a non-CPU master |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_mid | output | IDW | Master tag forwarded to memory |
| mem_rsp_valid | input | 1 | Memory response valid, one per accepted request |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions check the following on every cycle:
- a stalled memory request holds steady;
- ready stays low while a memory request is outstanding;
- a write-back differs from the word it was built from in at most one bit;
- an alias read answer never has bits above bit 0 set;
- a refused access yields zero data and no memory request;
- response pulses last exactly one cycle.

Some behaviour only the bench scenarios can show:
- the arithmetic of the translation, including the address that reaches memory;
- which bit lane a byte offset selects;
- the write-data bits that are ignored;
- the window edges;
- memory contents left unchanged after a refused write, and the effect of a read-modify-write when the memory stalls.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

    localparam int unsigned DATA_W            = 32;
    localparam int unsigned POS_W             = $clog2(DATA_W);
    localparam int unsigned ALIAS_STRIDE_LOG2 = 5;   // 32 alias bytes per target byte
    localparam int unsigned LANE_SEL_W        = 2;   // byte lane within a word
    localparam int unsigned BIT_SEL_W         = 3;   // bit within a byte

    typedef enum logic [1:0] {
        ACC_PASS  = 2'd0,
        ACC_ALIAS = 2'd1,
        ACC_DENY  = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD_REQ,
        ST_FWD_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } ctl_state_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [POS_W-1:0] pos;
    } xlat_info_t;

    // Little-endian: lane 0 occupies the least significant byte.
    function automatic logic [POS_W-1:0] lane_pos(input logic [LANE_SEL_W-1:0] lane,
                                                  input logic [BIT_SEL_W-1:0]  bit_in_byte);
        return {lane, bit_in_byte};
    endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bitband_pkg::*;
#(
    parameter int             AW          = 32,
    parameter int             IDW         = 2,
    parameter logic [AW-1:0]  ALIAS_BASE  = 32'h2200_0000,
    parameter logic [AW-1:0]  TARGET_BASE = 32'h2000_0000,
    parameter int             SPAN_LOG2   = 25,
    parameter logic [IDW-1:0] CPU_ID      = '0
) (
    input  logic [AW-1:0]  addr,
    input  logic [IDW-1:0] mid,
    output xlat_info_t     info,
    output logic [AW-1:0]  word_addr
);

    localparam int OFF_W = SPAN_LOG2 - ALIAS_STRIDE_LOG2;

    logic [AW-1:0]    rel;
    logic             in_window;
    logic [OFF_W-1:0] byte_off;
    logic [AW-1:0]    word_off;
    logic             unused_rel_low;

    always_comb begin
        rel       = addr - ALIAS_BASE;
        in_window = (rel[AW-1:SPAN_LOG2] == '0);
        byte_off  = rel[SPAN_LOG2-1:ALIAS_STRIDE_LOG2];
        word_off  = AW'({byte_off[OFF_W-1:LANE_SEL_W], {LANE_SEL_W{1'b0}}});
        word_addr = TARGET_BASE + word_off;
        info.pos  = lane_pos(byte_off[LANE_SEL_W-1:0], rel[4:2]);
        if (!in_window)
            info.kind = ACC_PASS;
        else if (mid == CPU_ID)
            info.kind = ACC_ALIAS;
        else
            info.kind = ACC_DENY;
    end

    assign unused_rel_low = ^rel[1:0];

endmodule

// File: rtl/bb_bitop.sv
module bb_bitop
    import bitband_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [POS_W-1:0]  pos,
    input  logic              val,
    output logic [DATA_W-1:0] bit_word,
    output logic [DATA_W-1:0] merged
);

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_lane
            assign merged[g] = (pos == POS_W'(g)) ? val : word[g];
        end
    endgenerate

    assign bit_word = {{(DATA_W-1){1'b0}}, word[pos]};

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bitband_pkg::*;
#(
    parameter int AW  = 32,
    parameter int IDW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [AW-1:0]     up_addr,
    input  logic              up_we,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [IDW-1:0]    up_mid,
    input  xlat_info_t        info,
    input  logic [AW-1:0]     xl_addr,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_data,
    output logic              up_rsp_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [IDW-1:0]    mem_mid,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [POS_W-1:0]  op_pos,
    output logic              op_val,
    input  logic [DATA_W-1:0] bit_word,
    input  logic [DATA_W-1:0] merged
);

    ctl_state_e        state;
    acc_kind_e         kind_q;
    logic [AW-1:0]     addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDW-1:0]    mid_q;
    logic [POS_W-1:0]  pos_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic              rsp_err_q;
    logic [DATA_W-1:0] rd_word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            kind_q     <= ACC_PASS;
            addr_q     <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            mid_q      <= '0;
            pos_q      <= '0;
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
            rd_word_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (up_valid) begin
                        kind_q    <= info.kind;
                        we_q      <= up_we;
                        wdata_q   <= up_wdata;
                        mid_q     <= up_mid;
                        pos_q     <= info.pos;
                        rsp_err_q <= 1'b0;
                        unique case (info.kind)
                            ACC_PASS: begin
                                addr_q <= up_addr;
                                state  <= ST_FWD_REQ;
                            end
                            ACC_ALIAS: begin
                                addr_q <= xl_addr;
                                state  <= ST_RD_REQ;
                            end
                            default: begin
                                rsp_err_q  <= 1'b1;
                                rsp_data_q <= '0;
                                state      <= ST_RESP;
                            end
                        endcase
                    end
                end
                ST_FWD_REQ:  if (mem_ready) state <= ST_FWD_WAIT;
                ST_FWD_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_data_q <= mem_rdata;
                        state      <= ST_RESP;
                    end
                end
                ST_RD_REQ:   if (mem_ready) state <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (we_q) begin
                            rd_word_q <= mem_rdata;
                            wdata_q   <= merged;
                            state     <= ST_WR_REQ;
                        end else begin
                            rsp_data_q <= bit_word;
                            state      <= ST_RESP;
                        end
                    end
                end
                ST_WR_REQ:   if (mem_ready) state <= ST_WR_WAIT;
                ST_WR_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_data_q <= '0;
                        state      <= ST_RESP;
                    end
                end
                ST_RESP:     state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        up_ready     = (state == ST_IDLE);
        mem_valid    = (state == ST_FWD_REQ) || (state == ST_RD_REQ) || (state == ST_WR_REQ);
        mem_we       = (state == ST_FWD_REQ) ? we_q : (state == ST_WR_REQ);
        mem_addr     = addr_q;
        mem_wdata    = wdata_q;
        mem_mid      = mid_q;
        up_rsp_valid = (state == ST_RESP);
        up_rsp_data  = rsp_data_q;
        up_rsp_err   = rsp_err_q;
        op_pos       = pos_q;
        op_val       = wdata_q[0];
    end

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                       && $stable(mem_wdata))) else $error("mem request moved"); // R9

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !up_ready) else $error("ready high during memory phase"); // R6

    AST_WRITEBACK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_REQ) |-> ($countones(mem_wdata ^ rd_word_q) <= 1)) else $error("write-back touched several bits"); // R4

    AST_ALIAS_READ_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (up_rsp_valid && kind_q == ACC_ALIAS && !we_q) |-> (up_rsp_data[DATA_W-1:1] == '0)) else $error("alias read not zero-extended"); // R3

    AST_DENY_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (up_rsp_valid && up_rsp_err) |-> (up_rsp_data == '0)) else $error("refused access carried data"); // R8

    AST_DENY_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready && info.kind == ACC_DENY) |=> !mem_valid) else $error("refused access reached memory"); // R8

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        up_rsp_valid |=> !up_rsp_valid) else $error("response longer than one cycle"); // R11

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
    import bitband_pkg::*;
#(
    parameter int             AW          = 32,
    parameter int             IDW         = 2,
    parameter logic [AW-1:0]  ALIAS_BASE  = 32'h2200_0000,
    parameter logic [AW-1:0]  TARGET_BASE = 32'h2000_0000,
    parameter int             SPAN_LOG2   = 25,
    parameter logic [IDW-1:0] CPU_ID      = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [AW-1:0]     up_addr,
    input  logic              up_we,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [IDW-1:0]    up_mid,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_data,
    output logic              up_rsp_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [IDW-1:0]    mem_mid,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rdata
);

    xlat_info_t        info;
    logic [AW-1:0]     xl_addr;
    logic [POS_W-1:0]  op_pos;
    logic              op_val;
    logic [DATA_W-1:0] bit_word;
    logic [DATA_W-1:0] merged;

    bb_decode #(
        .AW(AW), .IDW(IDW), .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE),
        .SPAN_LOG2(SPAN_LOG2), .CPU_ID(CPU_ID)
    ) u_decode (
        .addr      (up_addr),
        .mid       (up_mid),
        .info      (info),
        .word_addr (xl_addr)
    );

    bb_bitop u_bitop (
        .word     (mem_rdata),
        .pos      (op_pos),
        .val      (op_val),
        .bit_word (bit_word),
        .merged   (merged)
    );

    bb_ctrl #(.AW(AW), .IDW(IDW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .up_valid      (up_valid),
        .up_ready      (up_ready),
        .up_addr       (up_addr),
        .up_we         (up_we),
        .up_wdata      (up_wdata),
        .up_mid        (up_mid),
        .info          (info),
        .xl_addr       (xl_addr),
        .up_rsp_valid  (up_rsp_valid),
        .up_rsp_data   (up_rsp_data),
        .up_rsp_err    (up_rsp_err),
        .mem_valid     (mem_valid),
        .mem_ready     (mem_ready),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_mid       (mem_mid),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rdata     (mem_rdata),
        .op_pos        (op_pos),
        .op_val        (op_val),
        .bit_word      (bit_word),
        .merged        (merged)
    );

endmodule

// File: tb/tb_bitband_xlate.sv
module tb_bitband_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:0] up_addr = '0;
    logic        up_we = 1'b0;
    logic [31:0] up_wdata = '0;
    logic [1:0]  up_mid = '0;
    logic        up_rsp_valid;
    logic [31:0] up_rsp_data;
    logic        up_rsp_err;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [1:0]  mem_mid;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitband_xlate dut (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_we(up_we),
        .up_wdata(up_wdata), .up_mid(up_mid),
        .up_rsp_valid(up_rsp_valid), .up_rsp_data(up_rsp_data), .up_rsp_err(up_rsp_err),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_mid(mem_mid),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
    );

    // Backing memory model: word index from address bits [11:2], response one cycle after accept.
    logic [31:0] bmem [0:1023];
    logic        stall = 1'b0;
    int          n_rd = 0;
    int          n_wr = 0;
    logic [31:0] last_addr = '0;
    logic [1:0]  last_mid = '0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                bmem[mem_addr[11:2]] <= mem_wdata;
                mem_rdata <= '0;
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= bmem[mem_addr[11:2]];
                n_rd <= n_rd + 1;
            end
            mem_rsp_valid <= 1'b1;
            last_addr <= mem_addr;
            last_mid  <= mem_mid;
        end
        mem_ready <= stall ? ~mem_ready : 1'b1;
    end

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [31:0] a, input logic we, input logic [31:0] wd,
                           input logic [1:0] mid, output logic [31:0] rdata,
                           output logic err, output bit busy, output bit ok,
                           output int drd, output int dwr);
        int t;
        int rd0;
        int wr0;
        @(negedge clk);
        rd0 = n_rd;
        wr0 = n_wr;
        up_valid = 1'b1; up_addr = a; up_we = we; up_wdata = wd; up_mid = mid;
        t = 0;
        while (!up_ready && t < TMO) begin @(negedge clk); t++; end
        @(negedge clk);
        up_valid = 1'b0;
        busy = 1'b0;
        t = 0;
        while (!up_rsp_valid && t < TMO) begin
            if (up_ready) busy = 1'b1;
            @(negedge clk);
            t++;
        end
        if (up_ready) busy = 1'b1;
        ok    = (t < TMO);
        rdata = up_rsp_data;
        err   = up_rsp_err;
        drd   = n_rd - rd0;
        dwr   = n_wr - wr0;
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
        logic [1:0]  mid;
        logic [31:0] exp_data;
        logic        exp_err;
        logic [1:0]  exp_rd;
        logic [1:0]  exp_wr;
        logic [31:0] exp_maddr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    // Preload: word 0x20000300 = 0x4, word 0x2000033C = 0x80000000, index 0 = 0x55, index 0x3FF = 0xDEAD0000.
    localparam vec_t VEC [NV] = '{
        '{32'h2200_6008, 1'b0, 32'h0,         2'd0, 32'h1,         1'b0, 2'd1, 2'd0, 32'h2000_0300, 4'd3}, // R3 bit2 set
        '{32'h2200_600C, 1'b0, 32'h0,         2'd0, 32'h0,         1'b0, 2'd1, 2'd0, 32'h2000_0300, 4'd3}, // R3 bit3 clear
        '{32'h2200_600C, 1'b1, 32'h1,         2'd0, 32'h0,         1'b0, 2'd1, 2'd1, 32'h2000_0300, 4'd4}, // R4 set bit3
        '{32'h2000_0300, 1'b0, 32'h0,         2'd0, 32'h0000_000C, 1'b0, 2'd1, 2'd0, 32'h2000_0300, 4'd4}, // R4 readback
        '{32'h2200_6008, 1'b1, 32'hFFFF_FFFE, 2'd0, 32'h0,         1'b0, 2'd1, 2'd1, 32'h2000_0300, 4'd5}, // R5 clear bit2
        '{32'h2000_0300, 1'b0, 32'h0,         2'd0, 32'h0000_0008, 1'b0, 2'd1, 2'd0, 32'h2000_0300, 4'd5}, // R5 readback
        '{32'h2200_67FC, 1'b0, 32'h0,         2'd0, 32'h1,         1'b0, 2'd1, 2'd0, 32'h2000_033C, 4'd7}, // R7 lane3 bit31
        '{32'h2200_6780, 1'b1, 32'h1,         2'd0, 32'h0,         1'b0, 2'd1, 2'd1, 32'h2000_033C, 4'd7}, // R7 lane0 bit0
        '{32'h2000_033C, 1'b0, 32'h0,         2'd0, 32'h8000_0001, 1'b0, 2'd1, 2'd0, 32'h2000_033C, 4'd7}, // R7 readback
        '{32'h2200_6008, 1'b0, 32'h0,         2'd1, 32'h0,         1'b1, 2'd0, 2'd0, 32'h0,         4'd8}, // R8 other read
        '{32'h2200_6008, 1'b1, 32'h1,         2'd1, 32'h0,         1'b1, 2'd0, 2'd0, 32'h0,         4'd8}, // R8 other write
        '{32'h2000_0300, 1'b0, 32'h0,         2'd0, 32'h0000_0008, 1'b0, 2'd1, 2'd0, 32'h2000_0300, 4'd8}, // R8 unchanged
        '{32'h2000_0010, 1'b1, 32'hA5A5_0001, 2'd1, 32'h0,         1'b0, 2'd0, 2'd1, 32'h2000_0010, 4'd1}, // R1 other write
        '{32'h2000_0010, 1'b0, 32'h0,         2'd1, 32'hA5A5_0001, 1'b0, 2'd1, 2'd0, 32'h2000_0010, 4'd1}, // R1 other read
        '{32'h21FF_FFFC, 1'b0, 32'h0,         2'd0, 32'hDEAD_0000, 1'b0, 2'd1, 2'd0, 32'h21FF_FFFC, 4'd2}, // R2 below window
        '{32'h2400_0000, 1'b0, 32'h0,         2'd0, 32'h0000_0055, 1'b0, 2'd1, 2'd0, 32'h2400_0000, 4'd2}, // R2 window end
        '{32'h23FF_FFFC, 1'b0, 32'h0,         2'd0, 32'h1,         1'b0, 2'd1, 2'd0, 32'h200F_FFFC, 4'd2}, // R2 last alias word
        '{32'h2200_601C, 1'b1, 32'h0000_0003, 2'd0, 32'h0,         1'b0, 2'd1, 2'd1, 32'h2000_0300, 4'd5}, // R5 set bit7
        '{32'h2000_0300, 1'b0, 32'h0,         2'd0, 32'h0000_0088, 1'b0, 2'd1, 2'd0, 32'h2000_0300, 4'd4}  // R4 readback
    };

    initial begin
        logic [31:0] rd;
        logic        er;
        bit          busy;
        bit          ok;
        int          drd;
        int          dwr;
        string       rq;
        for (int i = 0; i < 1024; i++) bmem[i] = '0;
        bmem[10'h0C0] = 32'h0000_0004;
        bmem[10'h0CF] = 32'h8000_0000;
        bmem[10'h000] = 32'h0000_0055;
        bmem[10'h3FF] = 32'hDEAD_0000;

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(up_ready == 1'b1, "R10", "up_ready in reset", {31'b0, up_ready}, 32'h1);
        check(mem_valid == 1'b0, "R10", "mem_valid in reset", {31'b0, mem_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(up_ready == 1'b1 && mem_valid == 1'b0 && up_rsp_valid == 1'b0, "R10",
              "idle after reset", {29'b0, up_ready, mem_valid, up_rsp_valid}, 32'h4);

        for (int v = 0; v < NV; v++) begin
            rq = $sformatf("R%0d", VEC[v].req);
            run_txn(VEC[v].addr, VEC[v].we, VEC[v].wdata, VEC[v].mid, rd, er, busy, ok, drd, dwr);
            check(ok, "R11", $sformatf("vec %0d response seen", v), {31'b0, ok}, 32'h1);
            check(rd == VEC[v].exp_data && er == VEC[v].exp_err, rq,
                  $sformatf("vec %0d data/err(err=%0d exp %0d)", v, er, VEC[v].exp_err),
                  rd, VEC[v].exp_data);
            check(drd == int'(VEC[v].exp_rd) && dwr == int'(VEC[v].exp_wr), rq,
                  $sformatf("vec %0d mem reads/writes", v), 32'(drd * 16 + dwr),
                  32'(VEC[v].exp_rd * 16 + VEC[v].exp_wr));
            if (VEC[v].exp_rd != 0 || VEC[v].exp_wr != 0)
                check(last_addr == VEC[v].exp_maddr && last_mid == VEC[v].mid, rq,
                      $sformatf("vec %0d mem address/tag", v), last_addr, VEC[v].exp_maddr);
            check(!busy, "R6", $sformatf("vec %0d ready low until response", v),
                  {31'b0, busy}, 32'h0);
        end

        // R9 and R4 with a stalling memory: set bit4 of 0x20000300 (0x88 -> 0x98).
        stall = 1'b1;
        run_txn(32'h2200_6010, 1'b1, 32'h1, 2'd0, rd, er, busy, ok, drd, dwr);
        check(ok && rd == 32'h0 && !er, "R9", "stalled alias write response", rd, 32'h0);
        check(drd == 1 && dwr == 1, "R4", "stalled alias write traffic", 32'(drd * 16 + dwr), 32'h11);
        check(!busy, "R6", "stalled alias write blocks ready", {31'b0, busy}, 32'h0);
        run_txn(32'h2000_0300, 1'b0, 32'h0, 2'd0, rd, er, busy, ok, drd, dwr);
        check(rd == 32'h0000_0098, "R9", "stalled write-back result", rd, 32'h0000_0098);
        run_txn(32'h2200_6010, 1'b0, 32'h0, 2'd0, rd, er, busy, ok, drd, dwr);
        check(rd == 32'h1, "R3", "stalled alias read bit4", rd, 32'h1);
        stall = 1'b0;

        // R10: reset mid-run returns the block to idle.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(up_ready == 1'b1 && mem_valid == 1'b0 && up_rsp_valid == 1'b0, "R10",
              "idle after second reset", {29'b0, up_ready, mem_valid, up_rsp_valid}, 32'h4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule